// File: doc/BRIEF.md
# Type-C Port Controller Register File with Change Interrupt

This block is the register file behind the serial management port of a Type-C port controller. The serial slave decodes each bus transfer into a single-byte access: a strobe, a direction, a register index and write data. The register file answers reads one cycle after the strobe.

It holds four bytes:
- a fixed identity byte;
- a control byte that drives the connection state machine: the role, the try preference, the advertised current, accessory support and an interrupt mask;
- an event byte that records the latest attach or detach;
- a status byte that copies the connection state machine's outputs on every clock.

An active-low interrupt line tells the host that something has changed since the last read. Reading the event byte clears the event code. The mask bit hides the interrupt but keeps the pending change. A two-bit strap input sets the 7-bit slave address. When the strap is left open, register mode is off: the block then ignores the host and holds the interrupt line released.

Top module: `tcpc_status_regs`

## Requirements
- R1: With `strap_lvl` = 01 (tied high), `slave_addr` is 7'h68 and `reg_mode_en` is 1. With 00 (tied low), `slave_addr` is 7'h60 and `reg_mode_en` is 1. With `strap_lvl[1]` = 1 (open), `slave_addr` is 0 and `reg_mode_en` is 0.
- R2: Register 0x01 reads 8'h16: version 00010 in bits 7:3 and vendor 110 in bits 2:0. Writes to it have no effect.
- R3: Register 0x02 resets to 8'h00, is written by a host write, and reads back what was stored. `ctrl_out` always shows its content. Field layout: bit 7 accessory support (0 = supported); bits 6:5 try mode (01 try-sink, 10 try-source, 00/11 none); bits 4:3 advertised current (00 default, 01 1.5A, 10 3.0A); bits 2:1 role (00 sink, 01 source, 10 dual-role); bit 0 interrupt mask (1 = masked).
- R4: A write whose current field or role field holds the reserved code 11 leaves that field at its old value. The other fields of the same write still take effect.
- R5: Register 0x04 reads {vbus, current[1:0], port[2:0], side[1:0]}, captured at each clock from `vbus_det`, `chg_level`, `port_state` and `plug_side`. Port codes: 000 idle, 001 sink, 010 source, 011 audio accessory, 100 debug accessory. A port input of 101–111 is stored as 000.
- R6: Register 0x03 reads {6'b0, code}. The code is 01 after an `ev_attach` pulse and 10 after an `ev_detach` pulse. The newest event replaces an older one. Detach wins when both pulses come in the same cycle.
- R7: A host read of 0x03 returns the current code and then sets it to 00. An event in the same cycle as that read is kept.
- R8: A pending-change flag is set by any change of the status byte and by any event pulse. It is cleared by any host read that does not coincide with such a change. `int_n` is 0 while the flag is set, unmasked and in register mode, and 1 otherwise. Host writes do not set the flag.
- R9: With the mask bit at 1, `int_n` stays at 1 while the flag is kept. Clearing the mask without an intervening read drives `int_n` to 0 again.
- R10: Reads of index 0 or of indexes above 0x04 return 0. Writes to indexes other than 0x02 change no register.
- R11: With register mode off, host reads return 0, host writes are ignored, host reads do not clear the flag, and `int_n` is 1.
- R12: `rd_data` updates on the clock edge that samples a read strobe, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_lvl | input | 2 | Address strap: 00 low, 01 high, 1x open |
| slave_addr | output | 7 | Selected 7-bit slave address |
| reg_mode_en | output | 1 | Register mode enabled |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Register index |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after a read strobe |
| vbus_det | input | 1 | VBUS seen while sinking |
| chg_level | input | 2 | Current level seen as sink |
| port_state | input | 3 | Attached partner kind |
| plug_side | input | 2 | Plug orientation |
| ev_attach | input | 1 | Attach event pulse |
| ev_detach | input | 1 | Detach event pulse |
| ctrl_out | output | 8 | Control byte to the state machine |
| int_n | output | 1 | Active-low change interrupt |

## Verification
The hardest cases to reach from the ports are coincidences: a read of the event byte in the same cycle as a new event, and a change that stays pending while it is masked or while the strap is open and then shows up again. Directed sequences build each coincidence on purpose. This covers a read that races a new event, a masked event followed by an unmask write with no read in between, and an event taken while the strap is open before the strap returns. A seeded random phase then mixes accesses, event pulses, status changes and strap moves, and compares every cycle against a bench model.

// File: rtl/tcr_pkg.sv
// Shared constants and types for the Type-C register file.
// Assumes byte-wide registers and an 8-bit register index.
package tcr_pkg;
    localparam int DATA_W     = 8;
    localparam int REG_ADDR_W = 8;
    localparam int NUM_MAPPED = 5;

    localparam logic [7:0] ADR_ID   = 8'h01;
    localparam logic [7:0] ADR_CTRL = 8'h02;
    localparam logic [7:0] ADR_INT  = 8'h03;
    localparam logic [7:0] ADR_STAT = 8'h04;

    localparam logic [4:0] VERSION_CODE = 5'b00010;
    localparam logic [2:0] VENDOR_CODE  = 3'b110;

    typedef enum logic [1:0] {
        EVT_NONE   = 2'b00,
        EVT_ATTACH = 2'b01,
        EVT_DETACH = 2'b10
    } evt_code_e;

    localparam logic [2:0] PS_IDLE  = 3'd0;
    localparam logic [2:0] PS_DEBUG = 3'd4;

    typedef struct packed {
        logic       vbus_seen;
        logic [1:0] chg_level;
        logic [2:0] port_kind;
        logic [1:0] plug_side;
    } cc_status_t;
endpackage

// File: rtl/tcr_strap.sv
// Decodes the three-level address strap into a slave address and a mode enable.
// Assumes the pad logic reports an open strap by setting bit 1.
module tcr_strap #(
    parameter logic [6:0] ADDR_HI = 7'h68,
    parameter logic [6:0] ADDR_LO = 7'h60
) (
    input  logic [1:0] strap_lvl,
    output logic [6:0] slave_addr,
    output logic       reg_mode_en
);
    // Pick the address from the strap level; an open strap gives no address.
    always_comb begin
        reg_mode_en = ~strap_lvl[1];
        if (strap_lvl[1])
            slave_addr = '0;
        else if (strap_lvl[0])
            slave_addr = ADDR_HI;
        else
            slave_addr = ADDR_LO;
    end
endmodule

// File: rtl/tcr_status_cap.sv
// Captures the connection state machine's outputs into the status byte each
// clock. Reports when the captured value is about to change.
// Assumes the inputs are synchronous to clk.
module tcr_status_cap
    import tcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vbus_i,
    input  logic [1:0] chg_i,
    input  logic [2:0] port_i,
    input  logic [1:0] side_i,
    output cc_status_t stat_q,
    output logic       changed_o
);
    cc_status_t stat_d;

    // Pack the inputs and fold undefined port codes to idle.
    always_comb begin
        stat_d.vbus_seen = vbus_i;
        stat_d.chg_level = chg_i;
        stat_d.port_kind = (port_i > PS_DEBUG) ? PS_IDLE : port_i;
        stat_d.plug_side = side_i;
    end

    assign changed_o = (stat_d != stat_q);

    // Status byte register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= stat_d;
    end

    // R5
    port_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q.port_kind <= PS_DEBUG);
    // R5
    vbus_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stat_q.vbus_seen == $past(vbus_i));
endmodule

// File: rtl/tcr_ctrl_reg.sv
// Control byte, written by the host. A write carrying the reserved code 11 in
// the current or role field keeps that field's previous value.
// Assumes wr_en is already qualified by register mode and the index.
module tcr_ctrl_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_q
);
    localparam int ROLE_LO = 1;
    localparam int CUR_LO  = 3;
    localparam int NUM_GUARDED = 2;
    localparam int GUARD_LO [NUM_GUARDED] = '{ROLE_LO, CUR_LO};

    logic [DW-1:0] ctrl_d;

    // Merge the write data, keeping any guarded field that carries code 11.
    always_comb begin
        ctrl_d = wdata;
        for (int f = 0; f < NUM_GUARDED; f++) begin
            if (wdata[GUARD_LO[f] +: 2] == 2'b11)
                ctrl_d[GUARD_LO[f] +: 2] = ctrl_q[GUARD_LO[f] +: 2];
        end
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= ctrl_d;
    end

    // R4
    role_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[ROLE_LO +: 2] != 2'b11);
    // R4
    cur_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CUR_LO +: 2] != 2'b11);
    // R3
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/tcr_event.sv
// Event code register and pending-change flag, which drive the interrupt line.
// Assumes event pulses last one clock and host_rd_i is already qualified.
module tcr_event
    import tcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_attach_i,
    input  logic       ev_detach_i,
    input  logic       host_rd_i,
    input  logic       int_rd_i,
    input  logic       stat_chg_i,
    input  logic       mask_i,
    input  logic       mode_en_i,
    output logic [1:0] evt_q,
    output logic       int_n_o
);
    logic pend_q;
    logic any_evt;

    assign any_evt = ev_attach_i | ev_detach_i;

    // Event code: newest event wins, detach beats attach, a read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= EVT_NONE;
        else if (ev_detach_i)
            evt_q <= EVT_DETACH;
        else if (ev_attach_i)
            evt_q <= EVT_ATTACH;
        else if (int_rd_i)
            evt_q <= EVT_NONE;
    end

    // Pending flag: set by a change, cleared by a host read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (stat_chg_i || any_evt)
            pend_q <= 1'b1;
        else if (host_rd_i)
            pend_q <= 1'b0;
    end

    assign int_n_o = ~(pend_q & ~mask_i & mode_en_i);

    // R6
    det_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_detach_i |=> evt_q == EVT_DETACH);
    // R6
    att_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_attach_i && !ev_detach_i |=> evt_q == EVT_ATTACH);
    // R7
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_rd_i && !any_evt |=> evt_q == EVT_NONE);
    // R8
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_i && !stat_chg_i && !any_evt |=> int_n_o);
    // R9
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |-> int_n_o);
    // R11
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en_i |-> int_n_o);
endmodule

// File: rtl/tcpc_status_regs.sv
// Top of the Type-C register file. It decodes host accesses, muxes read data,
// and connects the strap decoder, control byte, status capture and interrupt
// logic. Assumes a single-cycle access strobe from the serial slave.
module tcpc_status_regs
    import tcr_pkg::*;
#(
    parameter int         AW         = REG_ADDR_W,
    parameter int         DW         = DATA_W,
    parameter logic [6:0] ADDR_HI    = 7'h68,
    parameter logic [6:0] ADDR_LO    = 7'h60,
    parameter logic [4:0] ID_VERSION = VERSION_CODE,
    parameter logic [2:0] ID_VENDOR  = VENDOR_CODE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    strap_lvl,
    output logic [6:0]    slave_addr,
    output logic          reg_mode_en,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] rd_data,
    input  logic          vbus_det,
    input  logic [1:0]    chg_level,
    input  logic [2:0]    port_state,
    input  logic [1:0]    plug_side,
    input  logic          ev_attach,
    input  logic          ev_detach,
    output logic [DW-1:0] ctrl_out,
    output logic          int_n
);
    localparam logic [DW-1:0] ID_BYTE = DW'({ID_VERSION, ID_VENDOR});

    logic                  host_rd;
    logic                  host_wr;
    logic [NUM_MAPPED-1:0] reg_hit;
    logic [DW-1:0]         rd_map [NUM_MAPPED];
    logic [DW-1:0]         rd_sel;
    logic [1:0]            evt_code;
    cc_status_t            stat_q;
    logic                  stat_chg;

    tcr_strap #(.ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)) u_strap (
        .strap_lvl   (strap_lvl),
        .slave_addr  (slave_addr),
        .reg_mode_en (reg_mode_en)
    );

    assign host_rd = reg_mode_en & acc_valid & ~acc_write;
    assign host_wr = reg_mode_en & acc_valid & acc_write;

    // One decode line per mapped index.
    for (genvar gi = 0; gi < NUM_MAPPED; gi++) begin : g_hit
        assign reg_hit[gi] = (acc_addr == AW'(gi));
    end

    tcr_ctrl_reg #(.DW(DW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (host_wr & reg_hit[ADR_CTRL[2:0]]),
        .wdata  (acc_wdata),
        .ctrl_q (ctrl_out)
    );

    tcr_status_cap u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .vbus_i    (vbus_det),
        .chg_i     (chg_level),
        .port_i    (port_state),
        .side_i    (plug_side),
        .stat_q    (stat_q),
        .changed_o (stat_chg)
    );

    tcr_event u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_attach_i (ev_attach),
        .ev_detach_i (ev_detach),
        .host_rd_i   (host_rd),
        .int_rd_i    (host_rd & reg_hit[ADR_INT[2:0]]),
        .stat_chg_i  (stat_chg),
        .mask_i      (ctrl_out[0]),
        .mode_en_i   (reg_mode_en),
        .evt_q       (evt_code),
        .int_n_o     (int_n)
    );

    // Read multiplexer: an unmapped or unused index reads zero.
    always_comb begin
        rd_map[0] = '0;
        rd_map[1] = ID_BYTE;
        rd_map[2] = ctrl_out;
        rd_map[3] = DW'(evt_code);
        rd_map[4] = DW'(stat_q);
        rd_sel    = '0;
        for (int i = 0; i < NUM_MAPPED; i++)
            rd_sel = rd_sel | (rd_map[i] & {DW{reg_hit[i]}});
    end

    // Read data register, loaded on every read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (acc_valid && !acc_write)
            rd_data <= reg_mode_en ? rd_sel : '0;
    end

    // R1
    strap_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_mode_en |-> (slave_addr == ADDR_HI || slave_addr == ADDR_LO));
    // R2
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && acc_addr == AW'(ADR_ID) |=> rd_data == ID_BYTE);
    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && (acc_addr == '0 || acc_addr > AW'(ADR_STAT))
        |=> rd_data == '0);
    // R11
    off_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && !reg_mode_en |=> rd_data == '0);
    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> $stable(rd_data));
endmodule

// File: tb/tb_tcpc_status_regs.sv
module tb_tcpc_status_regs;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [1:0] strap_lvl = 2'b01;
    logic [6:0] slave_addr;
    logic       reg_mode_en;
    logic       acc_valid = 0, acc_write = 0;
    logic [7:0] acc_addr = 0, acc_wdata = 0;
    logic [7:0] rd_data;
    logic       vbus_det = 0;
    logic [1:0] chg_level = 0;
    logic [2:0] port_state = 0;
    logic [1:0] plug_side = 0;
    logic       ev_attach = 0, ev_detach = 0;
    logic [7:0] ctrl_out;
    logic       int_n;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    tcpc_status_regs dut (.*);

    // Reference model written from the requirements.
    logic [7:0] m_ctrl = 0, m_stat = 0, m_rd = 0;
    logic [1:0] m_evt = 0;
    logic       m_flag = 0;

    function automatic logic [7:0] f_stat(input logic v, input logic [1:0] c,
                                          input logic [2:0] p, input logic [1:0] s);
        return {v, c, (p > 3'd4) ? 3'd0 : p, s};
    endfunction

    function automatic logic [7:0] f_ctrl(input logic [7:0] old, input logic [7:0] w);
        logic [7:0] n = w;
        if (w[2:1] == 2'b11) n[2:1] = old[2:1];
        if (w[4:3] == 2'b11) n[4:3] = old[4:3];
        return n;
    endfunction

    function automatic logic [7:0] f_read(input logic [7:0] a);
        case (a)
            8'h01:   return 8'h16;
            8'h02:   return m_ctrl;
            8'h03:   return {6'b0, m_evt};
            8'h04:   return m_stat;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        logic mode, rd, wr;
        logic [7:0] sn;
        mode = !strap_lvl[1];
        rd = acc_valid && !acc_write;
        wr = mode && acc_valid && acc_write;
        sn = f_stat(vbus_det, chg_level, port_state, plug_side);
        if (!rst_n) begin
            m_ctrl <= 0; m_stat <= 0; m_rd <= 0; m_evt <= 0; m_flag <= 0;
        end else begin
            if (rd) m_rd <= mode ? f_read(acc_addr) : 8'h00;
            if (wr && acc_addr == 8'h02) m_ctrl <= f_ctrl(m_ctrl, acc_wdata);
            if (ev_detach) m_evt <= 2'b10;
            else if (ev_attach) m_evt <= 2'b01;
            else if (mode && rd && acc_addr == 8'h03) m_evt <= 2'b00;
            if (sn != m_stat || ev_attach || ev_detach) m_flag <= 1;
            else if (mode && rd) m_flag <= 0;
            m_stat <= sn;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] a);
        acc_valid = 1; acc_write = 0; acc_addr = a;
        tick();
        acc_valid = 0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d;
        tick();
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic pulse(input logic att, input logic det);
        ev_attach = att; ev_detach = det;
        tick();
        ev_attach = 0; ev_detach = 0;
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1D5EED));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8 reset state releases the interrupt; R1 high strap address
        chk("R8 reset int_n", int_n, 1);
        chk("R1 high strap addr", slave_addr, 7'h68);
        chk("R1 high strap mode", reg_mode_en, 1);
        do_read(8'h02);
        chk("R3 ctrl reset value", rd_data, 8'h00);
        do_read(8'h01);
        chk("R2 id byte", rd_data, 8'h16);
        do_write(8'h01, 8'hFF);
        do_read(8'h01);
        chk("R2 id write ignored", rd_data, 8'h16);
        do_write(8'h02, 8'h4B);
        do_read(8'h02);
        chk("R3 ctrl readback", rd_data, 8'h4B);
        chk("R3 ctrl_out", ctrl_out, 8'h4B);
        do_write(8'h02, 8'h1E);
        do_read(8'h02);
        chk("R4 reserved codes keep fields", rd_data, 8'h0A);
        do_write(8'h02, 8'h00);
        // R5 / R8 status capture raises the interrupt
        vbus_det = 1; chg_level = 2'b11; port_state = 3'b010; plug_side = 2'b10;
        tick();
        chk("R8 status change asserts", int_n, 0);
        do_read(8'h04);
        chk("R5 status byte", rd_data, 8'hEA);
        chk("R8 read releases", int_n, 1);
        port_state = 3'b110;
        tick();
        do_read(8'h04);
        chk("R5 illegal port code folds", rd_data, 8'hE2);
        // R6 / R7 event codes
        pulse(1, 0);
        chk("R8 event asserts", int_n, 0);
        do_read(8'h04);
        chk("R8 any read releases", int_n, 1);
        do_read(8'h03);
        chk("R6 attach code", rd_data, 8'h01);
        do_read(8'h03);
        chk("R7 clear on read", rd_data, 8'h00);
        pulse(1, 1);
        do_read(8'h03);
        chk("R6 detach wins tie", rd_data, 8'h02);
        pulse(0, 1);
        ev_attach = 1;
        do_read(8'h03);
        ev_attach = 0;
        chk("R7 read returns old code", rd_data, 8'h02);
        do_read(8'h03);
        chk("R7 racing event kept", rd_data, 8'h01);
        // R9 mask
        do_write(8'h02, 8'h01);
        pulse(0, 1);
        chk("R9 masked int_n high", int_n, 1);
        do_write(8'h02, 8'h00);
        chk("R9 unmask re-asserts", int_n, 0);
        do_read(8'h03);
        chk("R8 released after read", int_n, 1);
        // R10 unmapped
        do_read(8'h00);
        chk("R10 index 0 reads zero", rd_data, 8'h00);
        do_read(8'h07);
        chk("R10 index 7 reads zero", rd_data, 8'h00);
        do_read(8'hFF);
        chk("R10 index ff reads zero", rd_data, 8'h00);
        do_write(8'h04, 8'h00);
        do_read(8'h04);
        chk("R10 status write ignored", rd_data, 8'hE2);
        do_write(8'h03, 8'hFF);
        do_read(8'h03);
        chk("R10 event write ignored", rd_data, 8'h00);
        do_write(8'h09, 8'h55);
        do_read(8'h02);
        chk("R10 unmapped write leaves ctrl", rd_data, 8'h00);
        // R11 open strap
        strap_lvl = 2'b10;
        tick();
        chk("R1 open strap addr", slave_addr, 7'h00);
        chk("R11 open strap mode", reg_mode_en, 0);
        pulse(1, 0);
        chk("R11 int_n high when off", int_n, 1);
        do_read(8'h01);
        chk("R11 read returns zero", rd_data, 8'h00);
        do_write(8'h02, 8'h4B);
        strap_lvl = 2'b01;
        tick();
        chk("R11 pending kept across off", int_n, 0);
        do_read(8'h02);
        chk("R11 write ignored", rd_data, 8'h00);
        strap_lvl = 2'b00;
        tick();
        chk("R1 low strap addr", slave_addr, 7'h60);
        // R12 hold between reads
        do_read(8'h01);
        acc_valid = 1; acc_write = 1; acc_addr = 8'h02; acc_wdata = 8'h00;
        tick();
        acc_valid = 0; acc_write = 0;
        chk("R12 rd_data holds", rd_data, 8'h16);

        // Random phase compared against the model
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom % 64;
            strap_lvl = (r == 0) ? 2'b10 : (r < 8) ? 2'b00 : 2'b01;
            acc_valid = ($urandom % 3) == 0;
            acc_write = $urandom % 2;
            acc_addr  = (($urandom % 8) == 0) ? 8'($urandom) : 8'($urandom % 6);
            acc_wdata = 8'($urandom);
            ev_attach = ($urandom % 16) == 0;
            ev_detach = ($urandom % 20) == 0;
            if (($urandom % 8) == 0) begin
                vbus_det = $urandom % 2; chg_level = 2'($urandom);
                port_state = 3'($urandom); plug_side = 2'($urandom);
            end
            tick();
            chk("R8 R9 R11 random int_n", int_n,
                !(!strap_lvl[1] && m_flag && !m_ctrl[0]));
            chk("R2 R5 R6 R10 R12 random rd_data", rd_data, m_rd);
            chk("R3 R4 random ctrl_out", ctrl_out, m_ctrl);
        end
        acc_valid = 0; ev_attach = 0; ev_detach = 0;
        finish_run();
    end
endmodule